// File: doc/BRIEF.md
# Key-Guarded System Configuration Register Block

This block holds a small set of chip-wide configuration words behind a software key. Two words are guarded: a device configuration word, whose bits steer pin sharing and peripheral enables elsewhere in the chip, and an audio clock divider word. Neither guarded word can change unless the bus write immediately before the update was the key value written to the lock slot. The key opens the lock for exactly one following bus write of any kind. After that write, or after any write that is not the key, the lock is shut again. Bus reads leave the lock untouched. This lets software do a read, modify the value locally, write the key, and then write the new value.

One bit of the device configuration word requests a software reset. The request fires when software sets that bit and then clears it again. The block marks the clearing with a one-cycle pulse toward the reset controller. An information slot gives read-only access to a fixed revision field. Reads are combinational: the data appears in the same cycle as the read strobe.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset, the device configuration output equals DEVCFG_INIT, the clock divider output equals CLKDIV_INIT, the lock slot (word address 0) reads 0, and the reset-request output is low.
- R2: A write of a full word equal to KEY (default 0xAA) to the lock slot arms the lock. While it is armed, the lock slot reads 1 in bit 0 and 0 in every other bit.
- R3: While the lock is armed, a write to the device configuration word (address 1) or to the clock divider word (address 2) takes effect. The written value appears on the matching output from the next cycle.
- R4: A write to a guarded word while the lock is not armed is dropped, and the word keeps its value.
- R5: Any bus write that is not the key written to the lock slot disarms the lock. This includes writes to the information slot and writes to unmapped addresses.
- R6: Writing any value other than KEY to the lock slot clears a pending unlock.
- R7: Read cycles, and cycles with no strobe, never change the lock state. The sequence key write, read, guarded write therefore succeeds.
- R8: The information slot (address 3) reads REV placed at bits [REV_LSB +: REV_W], with all other bits 0. Writes to this slot have no effect on what it reads.
- R9: The reset-request output is high for exactly one cycle, the cycle in which the device configuration output first shows bit SWRST_BIT cleared after it was set. Setting the bit does not raise the output.
- R10: Addresses 1 and 2 read back the current guarded words. Unmapped addresses (4 and above) read 0, and the read data is 0 when no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the strobe cycle |
| devcfg_o | output | DATA_W | Device configuration word |
| clkdiv_o | output | DATA_W | Audio clock divider word |
| sw_reset_req_o | output | 1 | One-cycle software reset request |

## Verification
The bench builds the block with DATA_W=16, ADDR_W=3, SWRST_BIT=3, REV=9, REV_LSB=4 and REV_W=4. With these values the revision field sits away from bit 0, so a misplaced shift shows up in the read data. They also leave four unmapped addresses that can disarm the lock. The key stays at its default, so the bench can check that near-miss values such as 0x55 are rejected. A 16-bit word keeps the all-ones overwrite attempts easy to tell apart from the key.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int unsigned SLOT_LOCK   = 0;
  localparam int unsigned SLOT_DEVCFG = 1;
  localparam int unsigned SLOT_CLKDIV = 2;
  localparam int unsigned SLOT_INFO   = 3;
  localparam int unsigned NUM_GUARDED = 2;

  // slot index of guarded word g
  function automatic int unsigned guarded_slot(input int unsigned g);
    return (g == 0) ? SLOT_DEVCFG : SLOT_CLKDIV;
  endfunction

  // revision field placed into an otherwise zero word (64-bit carrier)
  function automatic logic [63:0] place_field(input logic [63:0] value,
                                              input int unsigned lsb,
                                              input int unsigned width);
    logic [63:0] mask;
    mask = (64'd1 << width) - 64'd1;
    return (value & mask) << lsb;
  endfunction
endpackage

// File: rtl/cfg_unlock_arm.sv
module cfg_unlock_arm #(
  parameter int unsigned DATA_W = 32,
  parameter logic [7:0]  KEY    = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              lock_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);
  localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(KEY);

  logic key_seen;
  assign key_seen = lock_hit && (wdata == KEY_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (wr_fire) armed <= key_seen;
  end

  // R7: no write, no change of lock state
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(armed));
  // R5: a write to any other slot consumes the unlock
  p_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !lock_hit) |=> !armed);
endmodule

// File: rtl/cfg_guarded_word.sv
module cfg_guarded_word #(
  parameter int unsigned       DATA_W = 32,
  parameter logic [DATA_W-1:0] INIT   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic              armed,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic accept;
  assign accept = sel_wr && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= INIT;
    else if (accept) q <= wdata;
  end

  // R3: an unlocked write lands
  p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && armed) |=> (q == $past(wdata)));
  // R4: a locked write is dropped
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !armed) |=> $stable(q));
endmodule

// File: rtl/cfg_fall_pulse.sv
module cfg_fall_pulse #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= INIT;
    else        level_d <= level;
  end

  assign pulse = level_d && !level;

  // R9: never two cycles in a row
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
  import cfgreg_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter logic [7:0]  KEY         = 8'hAA,
  parameter logic [DATA_W-1:0] DEVCFG_INIT = '0,
  parameter logic [DATA_W-1:0] CLKDIV_INIT = '0,
  parameter int unsigned SWRST_BIT   = 31,
  parameter int unsigned REV         = 5,
  parameter int unsigned REV_LSB     = 28,
  parameter int unsigned REV_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] devcfg_o,
  output logic [DATA_W-1:0] clkdiv_o,
  output logic              sw_reset_req_o
);
  localparam logic [DATA_W-1:0] INFO_WORD =
    DATA_W'(place_field(64'(REV), REV_LSB, REV_W));

  // named internal events
  logic lock_hit, info_hit, armed;
  logic [NUM_GUARDED-1:0] g_hit;
  logic [DATA_W-1:0] g_q [NUM_GUARDED];

  assign lock_hit = (addr_i == ADDR_W'(SLOT_LOCK));
  assign info_hit = (addr_i == ADDR_W'(SLOT_INFO));

  cfg_unlock_arm #(.DATA_W(DATA_W), .KEY(KEY)) u_arm (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_en_i), .lock_hit(lock_hit),
    .wdata(wdata_i), .armed(armed)
  );

  for (genvar g = 0; g < NUM_GUARDED; g++) begin : gen_word
    localparam logic [DATA_W-1:0] W_INIT = (g == 0) ? DEVCFG_INIT : CLKDIV_INIT;
    assign g_hit[g] = (addr_i == ADDR_W'(guarded_slot(g)));
    cfg_guarded_word #(.DATA_W(DATA_W), .INIT(W_INIT)) u_word (
      .clk(clk), .rst_n(rst_n), .sel_wr(wr_en_i && g_hit[g]),
      .armed(armed), .wdata(wdata_i), .q(g_q[g])
    );
  end

  assign devcfg_o = g_q[0];
  assign clkdiv_o = g_q[1];

  cfg_fall_pulse #(.INIT(DEVCFG_INIT[SWRST_BIT])) u_rst (
    .clk(clk), .rst_n(rst_n), .level(devcfg_o[SWRST_BIT]),
    .pulse(sw_reset_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (lock_hit)      rdata_o = DATA_W'(armed);
      else if (g_hit[0]) rdata_o = g_q[0];
      else if (g_hit[1]) rdata_o = g_q[1];
      else if (info_hit) rdata_o = INFO_WORD;
    end
  end

  // R9: pulse only on a 1 -> 0 step of the reset bit
  p_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_req_o |-> ($past(devcfg_o[SWRST_BIT]) && !devcfg_o[SWRST_BIT]));
  // R6: a non-key lock write leaves the block locked
  p_nonkey_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && lock_hit && wdata_i != DATA_W'(KEY)) |=> !armed);
  // R8: info writes never reach the guarded words
  p_info_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && info_hit) |=> ($stable(devcfg_o) && $stable(clkdiv_o)));
  // R2: lock read reports the armed state in bit 0 only
  p_lock_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && lock_hit) |-> (rdata_o[DATA_W-1:1] == '0));
endmodule

// File: tb/sim_sys_cfg_regs.sv
module sim_sys_cfg_regs;
  localparam int  PER  = 10;
  localparam int  DW   = 16;
  localparam int  AW   = 3;
  localparam logic [DW-1:0] DEV_I = 16'h0040;
  localparam logic [DW-1:0] DIV_I = 16'h0001;
  localparam int  SWB  = 3;
  localparam int  REVV = 9, REVL = 4, REVW = 4;

  typedef struct { int kind; logic [DW-1:0] exp; string tag; } item_t;
  // kind: 0 rdata, 1 devcfg, 2 clkdiv, 3 reset request

  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, devcfg, clkdiv;
  logic rreq;
  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  sys_cfg_regs #(.DATA_W(DW), .ADDR_W(AW), .DEVCFG_INIT(DEV_I),
    .CLKDIV_INIT(DIV_I), .SWRST_BIT(SWB), .REV(REVV), .REV_LSB(REVL),
    .REV_W(REVW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .devcfg_o(devcfg), .clkdiv_o(clkdiv),
    .sw_reset_req_o(rreq));

  function automatic logic [DW-1:0] rev_word();
    logic [DW-1:0] w = '0;
    for (int b = 0; b < REVW; b++) w[REVL+b] = (REVV >> b) & 1;
    return w;
  endfunction

  task automatic expect_out(int kind, logic [DW-1:0] e, string tag);
    item_t it; it.kind = kind; it.exp = e; it.tag = tag; q.push_back(it);
  endtask

  task automatic step(logic w, logic r, int a, logic [DW-1:0] d);
    wr = w; rd = r; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic idle(); step(0, 0, 0, '0); endtask
  task automatic write(int a, logic [DW-1:0] d); step(1, 0, a, d); endtask
  task automatic key(); write(0, 16'h00AA); endtask
  task automatic read(int a, logic [DW-1:0] e, string tag);
    expect_out(0, e, tag); step(0, 1, a, '0);
  endtask

  // monitor: compare all items queued for this cycle
  initial begin
    forever begin
      @(negedge clk); #(PER/4);
      while (q.size() > 0) begin
        item_t it; logic [DW-1:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = rdata;
          1: act = devcfg;
          2: act = clkdiv;
          default: act = DW'(rreq);
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(PER*5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_out(1, DEV_I, "R1 devcfg"); expect_out(2, DIV_I, "R1 clkdiv");
    expect_out(3, 0, "R1 reset req");
    read(0, 0, "R1 lock idle");
    // R4 write without key dropped
    write(1, 16'h1234);
    expect_out(1, DEV_I, "R4 devcfg kept"); idle();
    // R2 arm and read lock
    key(); read(0, 1, "R2 lock armed");
    // R7 read keeps unlock, R3 guarded write lands
    read(1, DEV_I, "R7 read devcfg");
    write(1, 16'h0120);
    expect_out(1, 16'h0120, "R3 devcfg set");
    read(0, 0, "R5 lock consumed");
    key(); write(2, 16'h00F3);
    expect_out(2, 16'h00F3, "R3 clkdiv set");
    read(2, 16'h00F3, "R10 clkdiv readback");
    read(1, 16'h0120, "R10 devcfg readback");
    // R5 write to info consumes unlock
    key(); write(3, 16'hFFFF); write(1, 16'hFFFF);
    expect_out(1, 16'h0120, "R5 after info write"); idle();
    // R5 unmapped write consumes unlock
    key(); write(5, 16'h00AA); write(2, 16'h7777);
    expect_out(2, 16'h00F3, "R5 after unmapped write"); idle();
    // R6 non-key to lock clears unlock
    key(); write(0, 16'h0055);
    read(0, 0, "R6 lock cleared");
    key(); write(0, 16'h0055); write(1, 16'h0F0F);
    expect_out(1, 16'h0120, "R6 guarded dropped"); idle();
    // R8 revision read and write-ignored
    read(3, rev_word(), "R8 revision");
    key(); write(3, 16'hFFFF);
    read(3, rev_word(), "R8 revision after write");
    // R9 set bit: no pulse; clear: one pulse
    key(); write(1, 16'h0128);
    expect_out(3, 0, "R9 no pulse on set"); expect_out(1, 16'h0128, "R9 bit set");
    idle();
    write(1, 16'h0120);
    expect_out(3, 0, "R9 no pulse on dropped clear"); idle();
    key(); write(1, 16'h0120);
    expect_out(3, 1, "R9 pulse on clear"); idle();
    expect_out(3, 0, "R9 pulse width"); idle();
    // R10 unmapped read and no strobe
    read(6, 0, "R10 unmapped read");
    expect_out(0, 0, "R10 no strobe"); idle();
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule